// File: doc/BRIEF.md
# Z-channel Viterbi decoder

This block recovers a data stream that was protected by a rate 1/20 convolutional code and sent over an optical link where the receiver can only see stray light added to a word: a transmitted 1 always arrives as 1, while a transmitted 0 may arrive as 1 because other transmitters share the medium. A 20-bit received word is offered with a valid strobe. Each offered word advances a 64-state trellis by one step through add-compare-select. The decoded data bit comes out 35 symbols later, read from the survivor history of the state that holds the lowest path metric.

The branch metric follows the channel's asymmetry. A branch that expects light in a position that stayed dark cannot be the one that was sent, so its metric jumps to the full word length. Any other branch costs one unit for each position that lit up where the branch expects darkness. Path metrics are renormalised on every step and clamped, so they stay in a fixed width for any stream length. Survivors use register exchange with a history of the traceback depth. The expected word for each branch is computed from a generator parameter when the design is elaborated.

Top module: `zc_viterbi_dec`

## Requirements
- R1: While reset is high and on the first cycle after it is released, out_valid is 0. After reset, state 0 holds metric 0 and every other state holds the largest metric, so decoding assumes the encoder starts in state 0.
- R2: out_valid is first 1 on the rising edge that follows the edge accepting the 35th word after reset. It is 0 on the edge that accepts that word and at every earlier point.
- R3: On an error-free channel, the out_bit values seen when out_valid is 1 equal the transmitted data bits, in order, starting with the first bit sent after reset.
- R4: If up to two positions per word that were sent as 0 arrive as 1, the decoded sequence still equals the transmitted data.
- R5: A cycle with in_valid low changes neither the trellis nor the output sequence, whatever in_word carries. out_valid is 1 for exactly one cycle for each accepted word past the fill, and it is 0 on any edge not preceded by an accepting edge.
- R6: Path metrics are renormalised by the previous minimum and clamped, so they never wrap. The smallest metric never exceeds 20. A run of 400 words, each with three added 1 positions, still decodes exactly.
- R7: A branch metric is 20 when any position is expected as 1 but received as 0. Otherwise it is the number of positions received as 1 but expected as 0, so it is 0 on an exact match. A word where a single expected 1 arrives as 0 therefore still decodes correctly.
- R8: The register of the code is {state, b}: 7 bits, the 6-bit state in the upper bits and the input bit b in bit 0. Codeword bit j is the XOR of that register ANDed with generator j, which sits at bits [7j+6:7j] of GEN. The next state is the lower six bits of that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | in_word holds a received word this cycle |
| in_word | input | 20 | Received hard-decision codeword |
| out_valid | output | 1 | out_bit carries a decoded bit |
| out_bit | output | 1 | Decoded data bit, oldest first |

## Verification
A wrong path metric or survivor bit does not show up at once. It shows up 35 accepted words later, as a decoded bit that differs from the scoreboard's queued data bit. A metric that wraps or a broken forced-maximum rule only appears under the noisy and erased streams, which is why those stream types are kept apart. A fill counter that is off by one moves the first out_valid pulse by one edge, and the bench checks that edge exactly. Garbage driven on in_word during idle gaps makes any leak from ignored cycles corrupt later bits.

// File: rtl/zc_pkg.sv
package zc_pkg;
  localparam int unsigned ZC_STATE_W = 6;
  localparam int unsigned ZC_CW_W    = 20;
  // generator j occupies bits [7j+6:7j]; bit 6 taps the oldest state bit, bit 0 the input bit
  localparam logic [ZC_CW_W*(ZC_STATE_W+1)-1:0] ZC_GEN = {
    7'h69, 7'h75, 7'h63, 7'h59, 7'h7B, 7'h4B, 7'h67, 7'h73, 7'h5D, 7'h6B,
    7'h57, 7'h7D, 7'h71, 7'h47, 7'h53, 7'h4F, 7'h6D, 7'h65, 7'h5B, 7'h79};
endpackage

// File: rtl/zc_bmu.sv
module zc_bmu #(
  parameter int unsigned CW_W = 20,
  parameter int unsigned BM_W = $clog2(CW_W + 1)
) (
  input  logic [CW_W-1:0] rx_word,
  input  logic [CW_W-1:0] exp_word,
  output logic [BM_W-1:0] metric
);
  logic            dark_miss;
  logic [BM_W-1:0] lit_extra;

  always_comb begin
    dark_miss = |(exp_word & ~rx_word);
    lit_extra = '0;
    for (int i = 0; i < CW_W; i++) begin
      lit_extra = lit_extra + BM_W'(rx_word[i] & ~exp_word[i]);
    end
    metric = dark_miss ? BM_W'(CW_W) : lit_extra;
  end
endmodule

// File: rtl/zc_acs.sv
module zc_acs #(
  parameter int unsigned PM_W = 8,
  parameter int unsigned BM_W = 5
) (
  input  logic [PM_W-1:0] pm_lo,
  input  logic [PM_W-1:0] pm_hi,
  input  logic [BM_W-1:0] bm_lo,
  input  logic [BM_W-1:0] bm_hi,
  input  logic [PM_W-1:0] floor_pm,
  output logic [PM_W-1:0] pm_out,
  output logic            pick_hi
);
  localparam logic [PM_W:0] PM_CAP = {1'b0, {PM_W{1'b1}}};

  logic [PM_W:0] sum_lo, sum_hi, best, diff;

  always_comb begin
    sum_lo  = {1'b0, pm_lo} + (PM_W+1)'(bm_lo);
    sum_hi  = {1'b0, pm_hi} + (PM_W+1)'(bm_hi);
    pick_hi = sum_hi < sum_lo;
    best    = pick_hi ? sum_hi : sum_lo;
    diff    = best - {1'b0, floor_pm};
    pm_out  = (diff > PM_CAP) ? PM_CAP[PM_W-1:0] : diff[PM_W-1:0];
  end
endmodule

// File: rtl/zc_min_find.sv
module zc_min_find #(
  parameter int unsigned N  = 64,
  parameter int unsigned W  = 8,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [W-1:0]  vals [N],
  output logic [W-1:0]  min_val,
  output logic [IW-1:0] min_idx
);
  always_comb begin
    min_val = vals[0];
    min_idx = '0;
    for (int i = 1; i < N; i++) begin
      if (vals[i] < min_val) begin
        min_val = vals[i];
        min_idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/zc_viterbi_dec.sv
module zc_viterbi_dec #(
  parameter int unsigned STATE_W = zc_pkg::ZC_STATE_W,
  parameter int unsigned CW_W    = zc_pkg::ZC_CW_W,
  parameter int unsigned DEPTH   = 35,
  parameter int unsigned PM_W    = 8,
  parameter logic [CW_W*(STATE_W+1)-1:0] GEN = zc_pkg::ZC_GEN
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [CW_W-1:0] in_word,
  output logic            out_valid,
  output logic            out_bit
);
  localparam int unsigned NS    = 1 << STATE_W;
  localparam int unsigned HALF  = NS / 2;
  localparam int unsigned BM_W  = $clog2(CW_W + 1);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  function automatic logic [CW_W-1:0] word_of(input logic [STATE_W:0] shreg);
    logic [CW_W-1:0] w;
    for (int j = 0; j < CW_W; j++) begin
      w[j] = ^(shreg & GEN[j*(STATE_W+1) +: (STATE_W+1)]);
    end
    return w;
  endfunction

  logic [PM_W-1:0]    pm_q    [NS];
  logic [PM_W-1:0]    pm_nx   [NS];
  logic [DEPTH-1:0]   path_q  [NS];
  logic [DEPTH-1:0]   path_nx [NS];
  logic [PM_W-1:0]    min_val;
  logic [STATE_W-1:0] min_idx;
  logic [CNT_W-1:0]   acc_cnt;
  logic               upd_q;

  zc_min_find #(.N(NS), .W(PM_W), .IW(STATE_W)) u_min (
    .vals(pm_q), .min_val(min_val), .min_idx(min_idx)
  );

  for (genvar n = 0; n < NS; n++) begin : g_st
    localparam logic [STATE_W-1:0] NXT = STATE_W'(n);
    localparam int unsigned P_LO = n / 2;
    localparam int unsigned P_HI = HALF + n / 2;
    localparam logic [CW_W-1:0] EXP_LO = word_of({1'b0, NXT});
    localparam logic [CW_W-1:0] EXP_HI = word_of({1'b1, NXT});

    logic [BM_W-1:0] bm_lo, bm_hi;
    logic            pick_hi;

    zc_bmu #(.CW_W(CW_W), .BM_W(BM_W)) u_bm_lo (
      .rx_word(in_word), .exp_word(EXP_LO), .metric(bm_lo)
    );
    zc_bmu #(.CW_W(CW_W), .BM_W(BM_W)) u_bm_hi (
      .rx_word(in_word), .exp_word(EXP_HI), .metric(bm_hi)
    );
    zc_acs #(.PM_W(PM_W), .BM_W(BM_W)) u_acs (
      .pm_lo(pm_q[P_LO]), .pm_hi(pm_q[P_HI]), .bm_lo(bm_lo), .bm_hi(bm_hi),
      .floor_pm(min_val), .pm_out(pm_nx[n]), .pick_hi(pick_hi)
    );

    assign path_nx[n] = pick_hi ? {path_q[P_HI][DEPTH-2:0], NXT[0]}
                                : {path_q[P_LO][DEPTH-2:0], NXT[0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NS; s++) begin
        pm_q[s]   <= (s == 0) ? '0 : {PM_W{1'b1}};
        path_q[s] <= '0;
      end
      acc_cnt   <= '0;
      upd_q     <= 1'b0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      if (in_valid) begin
        for (int s = 0; s < NS; s++) begin
          pm_q[s]   <= pm_nx[s];
          path_q[s] <= path_nx[s];
        end
        if (acc_cnt != CNT_W'(DEPTH)) acc_cnt <= acc_cnt + 1'b1;
      end
      upd_q     <= in_valid;
      out_valid <= upd_q && (acc_cnt == CNT_W'(DEPTH));
      if (upd_q) out_bit <= path_q[min_idx][DEPTH-1];
    end
  end
endmodule

// File: rtl/zc_viterbi_chk.sv
module zc_viterbi_chk #(
  parameter int unsigned CW_W  = 20,
  parameter int unsigned DEPTH = 35,
  parameter int unsigned PM_W  = 8,
  parameter int unsigned CNT_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             out_valid,
  input logic             upd_q,
  input logic [CNT_W-1:0] acc_cnt,
  input logic [PM_W-1:0]  min_val
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !out_valid); // R1
  AST_VALID_AFTER_FILL: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> acc_cnt == CNT_W'(DEPTH)); // R2
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
    !upd_q |=> !out_valid); // R5
  AST_IDLE_FILL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(acc_cnt)); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    min_val <= PM_W'(CW_W)); // R6
endmodule

bind zc_viterbi_dec zc_viterbi_chk #(
  .CW_W(CW_W), .DEPTH(DEPTH), .PM_W(PM_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
  .upd_q(upd_q), .acc_cnt(acc_cnt), .min_val(min_val)
);

// File: tb/test_zc_viterbi_dec.sv
module test_zc_viterbi_dec;
  localparam int unsigned CW_W  = 20;
  localparam int unsigned DEPTH = 35;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic [CW_W-1:0] in_word = '0;
  logic            out_valid, out_bit;

  int    errors = 0, checks = 0, n_out = 0;
  bit    done = 1'b0;
  string tag = "R3";
  bit    exp_q[$];
  logic [5:0] enc_state = '0;

  always #2 clk = ~clk;

  zc_viterbi_dec i_zc_viterbi_dec (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .out_valid(out_valid), .out_bit(out_bit)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // R8: encoder model built from the register layout {state, b}
  function automatic logic [CW_W-1:0] encode(input logic [5:0] st, input bit b);
    logic [CW_W-1:0] w;
    for (int j = 0; j < CW_W; j++) w[j] = ^({st, b} & zc_pkg::ZC_GEN[j*7 +: 7]);
    return w;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (out_valid && !rst) begin
      n_out++;
      if (exp_q.size() == 0) chk(1'b0, {tag, " extra output"}, 1, 0);
      else begin
        bit e;
        e = exp_q.pop_front();
        chk(out_bit == e, tag, out_bit, e);
      end
    end
  end

  // mode: 0 clean, 1..3 added ones, 9 one erased 1; starts and ends just after a negedge
  task automatic send(input bit b, input int mode, input int gap);
    logic [CW_W-1:0] w;
    w = encode(enc_state, b);
    enc_state = {enc_state[4:0], b};
    if (mode >= 1 && mode <= 3) begin
      for (int k = 0; k < mode; k++) w[$urandom_range(CW_W-1, 0)] = 1'b1;
    end else if (mode == 9 && w != '0) begin
      for (int t = 0; t < 200; t++) begin
        int p;
        p = $urandom_range(CW_W-1, 0);
        if (w[p]) begin w[p] = 1'b0; break; end
      end
    end
    in_valid = 1'b1;
    in_word  = w;
    exp_q.push_back(b);
    @(negedge clk);
    in_valid = 1'b0;
    for (int g = 0; g < gap; g++) begin
      in_word = CW_W'($urandom);
      @(negedge clk);
      if (g >= 1) chk(!out_valid, "R5 idle out_valid", out_valid, 0);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(!out_valid, "R1 out_valid in reset", out_valid, 0);
    rst = 1'b0;
    exp_q.delete();
    enc_state = '0;
    @(negedge clk);
    chk(!out_valid, "R1 out_valid after reset", out_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();

    // R2: fill window, exact edge of the first valid
    tag = "R3";
    for (int i = 0; i < DEPTH - 1; i++) send(1'($urandom), 0, (i % 3 == 0) ? 1 : 0);
    repeat (3) @(negedge clk);
    chk(n_out == 0, "R2 no output before fill", n_out, 0);
    in_valid = 1'b1;
    in_word  = encode(enc_state, 1'b1);
    enc_state = {enc_state[4:0], 1'b1};
    exp_q.push_back(1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    chk(!out_valid, "R2 not valid on accepting edge", out_valid, 0);
    @(negedge clk);
    chk(out_valid, "R2 valid one edge later", out_valid, 1);

    // R3: clean back-to-back stream
    tag = "R3";
    for (int i = 0; i < 200; i++) send(1'($urandom), 0, 0);

    // R4: OR interference, up to two added ones
    tag = "R4";
    for (int i = 0; i < 300; i++) send(1'($urandom), 1 + (i % 2), 0);

    // R5: idle gaps with garbage on in_word
    tag = "R5";
    for (int i = 0; i < 60; i++) send(1'($urandom), 0, 1 + (i % 3));

    // R7: occasional single erased 1
    tag = "R7";
    for (int i = 0; i < 200; i++) send((i % 40 == 5) ? 1'b1 : 1'($urandom), (i % 40 == 5) ? 9 : 0, 0);

    // R1 again after activity, then R6 heavy noise run
    repeat (4) @(negedge clk);
    do_reset();
    tag = "R6";
    for (int i = 0; i < 400; i++) send(1'($urandom), 3, 0);
    tag = "R6 tail";
    for (int i = 0; i < 60; i++) send(1'($urandom), 0, 0);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == DEPTH - 1, "R3 pending depth", exp_q.size(), DEPTH - 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule